// File: doc/BRIEF.md
# Device Address Table with Dynamic Address Assignment

This block holds a table of target-device entries that bus transfers refer to by a small device index. An entry describes one target in one of two ways: as a legacy two-wire device with a 7-bit static address, or as a device reached through an 8-bit dynamic field. In that field the top bit is a parity bit, chosen so that the whole 8-bit value has an odd number of ones. Software writes and reads the entries through a word-addressed register port. A read-only pointer register reports where the table starts and how many entries it has. A combinational lookup port turns a device index into the address to drive on the bus, and it flags dynamic entries whose parity bit is wrong.

An assignment sequencer takes a command word that gives a starting index and an entry count. It then offers the dynamic addresses of consecutive entries, in rising index order, to a bus engine that is represented here by a stub handshake. Each acknowledged offer uses up one entry. The run ends when the count is exhausted or when the stub reports that no more devices answer. The sequencer then sends a one-cycle response whose length field holds the number of entries in the run that received no device. While a run is in progress, the table ignores register writes.

Top module: `dev_addr_table`

## Requirements
- R1: The register at offset PTR_OFS reads back the table depth in bits 31:16, zero in bits 15:8 and the table start offset in bits 7:0. Writes to it have no effect.
- R2: Entry i is mapped at TBL_BASE + 4*i. Only bit 31 (legacy flag), bits 23:16 (dynamic field) and bits 6:0 (static address) are stored. All other bits read as zero, and so does every unmapped offset. All entries read as zero after reset.
- R3: A lookup of a legacy entry (bit 31 set) returns its static address with lk_legacy=1. A lookup of a non-legacy entry whose 8-bit dynamic field has odd parity returns the field's bits 6:0 with lk_legacy=0. In both cases lk_hit=1 and lk_parity_err=0.
- R4: A lookup of a non-zero, non-legacy entry whose dynamic field has even parity raises lk_parity_err and returns address 0 with lk_legacy=0.
- R5: An entry that holds all zeros is free. Writing zero frees an entry. A lookup of a free entry, or of an index at or above the depth, gives lk_hit=0, address 0 and no parity error.
- R6: A command is accepted only while the block is idle and only when bits 2:0 of cmd_word equal 3. Any other command is ignored, and busy stays low.
- R7: In an accepted command, bits 20:16 give the starting index and bits 25:21 give the count. While asg_req is high, asg_addr carries bits 6:0 of the current entry's dynamic field. Each asg_ack moves the run to the next higher index.
- R8: If asg_none is seen without asg_ack, the run stops. The response length then equals the entries of the run not yet handed out.
- R9: The count is clipped to the entries that remain from the start index to the end of the table. When the count is used up, the run ends with response length 0. A run with an effective count of 0 responds at once.
- R10: Register writes made while busy is high leave the table unchanged.
- R11: busy rises in the cycle after a command is accepted and stays high through the response. rsp_valid is high for exactly one cycle per accepted command. rsp_len is 0 whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_index | input | 5 | Device index to look up |
| lk_hit | output | 1 | Indexed entry is occupied |
| lk_legacy | output | 1 | Indexed entry is a legacy static-address device |
| lk_addr | output | 7 | Bus address for the indexed entry |
| lk_parity_err | output | 1 | Dynamic field of the indexed entry fails the odd-parity check |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 32 | Command word (type, start, count) |
| busy | output | 1 | Assignment run or response in progress |
| asg_req | output | 1 | Address offer to the bus engine |
| asg_addr | output | 7 | Offered dynamic address |
| asg_ack | input | 1 | A device took the offered address |
| asg_none | input | 1 | No further device answers |
| rsp_valid | output | 1 | One-cycle completion response |
| rsp_len | output | 16 | Count of entries in the run left unassigned |

## Verification
The bench builds the block with DEPTH set to 8, the table at offset 0x20 and the pointer register at offset 0x04. With a depth this small, a start index near the end of the table makes count clipping reachable: a start of 6 with a count of 5 leaves only two entries. Start indices at or beyond the depth, and lookups of indices past the table, are reachable as well. Runs that end in each of the three ways are exercised: count exhausted, no more devices, and zero effective count. Writes are issued in the middle of a run, with legacy, correct-parity and wrong-parity entries placed side by side.

// File: rtl/dat_pkg.sv
package dat_pkg;

   // Stored fields of one table entry (unused word bits are not kept)
   typedef struct packed {
      logic       legacy;
      logic [7:0] dyn;
      logic [6:0] stat;
   } dat_entry_t;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WALK = 2'd1,
      SEQ_RESP = 2'd2
   } seq_state_t;

   localparam logic [2:0] CMD_TYPE_ASSIGN = 3'd3;
   localparam int         IDX_W           = 5;
   localparam int         RUN_W           = IDX_W + 1;

   function automatic logic [31:0] entry_to_word(input dat_entry_t e);
      return {e.legacy, 7'b0, e.dyn, 9'b0, e.stat};
   endfunction

   function automatic dat_entry_t word_to_entry(input logic [31:0] w);
      dat_entry_t e;
      e.legacy = w[31];
      e.dyn    = w[23:16];
      e.stat   = w[6:0];
      return e;
   endfunction

endpackage

// File: rtl/dat_entry_store.sv
module dat_entry_store
   import dat_pkg::*;
#(
   parameter int DEPTH    = 32,
   parameter int ADDR_W   = 8,
   parameter int TBL_BASE = 32,
   parameter int PTR_OFS  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [31:0]             wdata,
   output logic [31:0]             rdata,
   output dat_entry_t [DEPTH-1:0]  entries
);

   localparam logic [15:0]       DEPTH_FIELD = 16'(DEPTH);
   localparam logic [7:0]        BASE_FIELD  = 8'(TBL_BASE);
   localparam logic [ADDR_W-1:0] PTR_ADDR    = ADDR_W'(PTR_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entries <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (addr == ADDR_W'(TBL_BASE + 4 * i))
               entries[i] <= word_to_entry(wdata);
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == PTR_ADDR)
         rdata = {DEPTH_FIELD, 8'h00, BASE_FIELD};
      for (int i = 0; i < DEPTH; i++) begin
         if (addr == ADDR_W'(TBL_BASE + 4 * i))
            rdata = entry_to_word(entries[i]);
      end
   end

endmodule

// File: rtl/dat_lookup.sv
module dat_lookup
   import dat_pkg::*;
#(
   parameter int DEPTH        = 32,
   parameter bit PARITY_CHECK = 1'b1
) (
   input  dat_entry_t [DEPTH-1:0] entries,
   input  logic [IDX_W-1:0]       index,
   output logic                   hit,
   output logic                   legacy,
   output logic [6:0]             addr,
   output logic                   par_err
);

   dat_entry_t sel;
   logic       bad;

   always_comb begin
      sel = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (index == IDX_W'(i))
            sel = entries[i];
      end
   end

   assign hit = (sel != '0);

   generate
      if (PARITY_CHECK) begin : g_par_on
         assign bad = hit && !sel.legacy && !(^sel.dyn);
      end else begin : g_par_off
         assign bad = 1'b0;
      end
   endgenerate

   assign par_err = bad;
   assign legacy  = hit && sel.legacy;

   always_comb begin
      if (!hit || bad)
         addr = '0;
      else if (sel.legacy)
         addr = sel.stat;
      else
         addr = sel.dyn[6:0];
   end

endmodule

// File: rtl/dat_assign_seq.sv
module dat_assign_seq
   import dat_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [31:0]            cmd_word,
   input  dat_entry_t [DEPTH-1:0] entries,
   input  logic                   asg_ack,
   input  logic                   asg_none,
   output logic                   busy,
   output logic                   asg_req,
   output logic [6:0]             asg_addr,
   output logic                   rsp_valid,
   output logic [15:0]            rsp_len,
   output logic [IDX_W-1:0]       cur_idx
);

   seq_state_t       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [RUN_W-1:0] left_q;
   logic [IDX_W-1:0] start_f;
   logic [IDX_W-1:0] count_f;
   logic [RUN_W-1:0] room;
   logic [RUN_W-1:0] eff;
   logic             accept;

   assign start_f = cmd_word[20:16];
   assign count_f = cmd_word[25:21];
   assign accept  = (state_q == SEQ_IDLE) && cmd_valid && (cmd_word[2:0] == CMD_TYPE_ASSIGN);

   always_comb begin
      room = (32'(start_f) < DEPTH) ? RUN_W'(DEPTH - 32'(start_f)) : '0;
      eff  = ({1'b0, count_f} < room) ? {1'b0, count_f} : room;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         left_q  <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: if (accept) begin
               state_q <= SEQ_WALK;
               idx_q   <= start_f;
               left_q  <= eff;
            end
            SEQ_WALK: begin
               if (left_q == '0) begin
                  state_q <= SEQ_RESP;
               end else if (asg_ack) begin
                  idx_q  <= idx_q + 1'b1;
                  left_q <= left_q - 1'b1;
                  if (left_q == RUN_W'(1))
                     state_q <= SEQ_RESP;
               end else if (asg_none) begin
                  state_q <= SEQ_RESP;
               end
            end
            SEQ_RESP: state_q <= SEQ_IDLE;
            default:  state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != SEQ_IDLE);
   assign asg_req   = (state_q == SEQ_WALK) && (left_q != '0);
   assign rsp_valid = (state_q == SEQ_RESP);
   assign rsp_len   = rsp_valid ? 16'(left_q) : 16'd0;
   assign cur_idx   = idx_q;

   always_comb begin
      asg_addr = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (asg_req && idx_q == IDX_W'(i))
            asg_addr = entries[i].dyn[6:0];
      end
   end

endmodule

// File: rtl/dev_addr_table.sv
module dev_addr_table
   import dat_pkg::*;
#(
   parameter int DEPTH        = 32,
   parameter int ADDR_W       = 8,
   parameter int TBL_BASE     = 32,
   parameter int PTR_OFS      = 4,
   parameter bit PARITY_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [4:0]        lk_index,
   output logic              lk_hit,
   output logic              lk_legacy,
   output logic [6:0]        lk_addr,
   output logic              lk_parity_err,
   input  logic              cmd_valid,
   input  logic [31:0]       cmd_word,
   output logic              busy,
   output logic              asg_req,
   output logic [6:0]        asg_addr,
   input  logic              asg_ack,
   input  logic              asg_none,
   output logic              rsp_valid,
   output logic [15:0]       rsp_len
);

   localparam int TBL_END = TBL_BASE + 4 * DEPTH;

   generate
      if (DEPTH < 1 || DEPTH > 32) begin : g_bad_depth
         $error("DEPTH must lie in 1..32");
      end
      if (ADDR_W < 3 || ADDR_W > 8) begin : g_bad_aw
         $error("ADDR_W must lie in 3..8");
      end
      if ((TBL_BASE % 4) != 0 || TBL_END > (1 << ADDR_W)) begin : g_bad_base
         $error("table must be word aligned and fit the register space");
      end
      if (PTR_OFS >= TBL_BASE && PTR_OFS < TBL_END) begin : g_bad_ptr
         $error("pointer register overlaps the table");
      end
   endgenerate

   dat_entry_t [DEPTH-1:0] tbl;
   logic [IDX_W-1:0]       seq_idx;
   logic                   store_wr;

   assign store_wr = reg_wr && !busy;

   dat_entry_store #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE), .PTR_OFS(PTR_OFS)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(store_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .entries(tbl)
   );

   dat_lookup #(
      .DEPTH(DEPTH), .PARITY_CHECK(PARITY_CHECK)
   ) u_lookup (
      .entries(tbl), .index(lk_index), .hit(lk_hit), .legacy(lk_legacy),
      .addr(lk_addr), .par_err(lk_parity_err)
   );

   dat_assign_seq #(
      .DEPTH(DEPTH)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .entries(tbl), .asg_ack(asg_ack), .asg_none(asg_none), .busy(busy),
      .asg_req(asg_req), .asg_addr(asg_addr), .rsp_valid(rsp_valid),
      .rsp_len(rsp_len), .cur_idx(seq_idx)
   );

endmodule

// File: rtl/dat_checker.sv
module dat_checker
   import dat_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   reg_wr,
   input logic                   busy,
   input dat_entry_t [DEPTH-1:0] tbl,
   input logic                   cmd_valid,
   input logic [31:0]            cmd_word,
   input logic                   asg_req,
   input logic                   asg_ack,
   input logic [IDX_W-1:0]       seq_idx,
   input logic                   lk_hit,
   input logic                   lk_legacy,
   input logic [6:0]             lk_addr,
   input logic                   lk_parity_err,
   input logic                   rsp_valid,
   input logic [15:0]            rsp_len
);

   a_r4_err_hides_addr: assert property (@(posedge clk) disable iff (!rst_n)
      lk_parity_err |-> (lk_addr == 7'd0 && !lk_legacy && lk_hit));

   a_r5_free_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (!lk_parity_err && lk_addr == 7'd0 && !lk_legacy));

   a_r6_bad_type_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && cmd_word[2:0] != CMD_TYPE_ASSIGN) |=> !busy);

   a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (asg_req && asg_ack) |=> (seq_idx == $past(seq_idx) + 1'b1));

   a_r7_req_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      asg_req |-> busy);

   a_r8_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (32'(rsp_len) <= DEPTH));

   a_r10_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr) |=> $stable(tbl));

   a_r11_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r11_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> busy);

   a_r11_len_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_len == 16'd0));

endmodule

bind dev_addr_table dat_checker #(.DEPTH(DEPTH)) u_dat_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .busy(busy), .tbl(tbl),
   .cmd_valid(cmd_valid), .cmd_word(cmd_word), .asg_req(asg_req),
   .asg_ack(asg_ack), .seq_idx(seq_idx), .lk_hit(lk_hit),
   .lk_legacy(lk_legacy), .lk_addr(lk_addr), .lk_parity_err(lk_parity_err),
   .rsp_valid(rsp_valid), .rsp_len(rsp_len)
);

// File: tb/dev_addr_table_tb_top.sv
module dev_addr_table_tb_top;

   localparam int N    = 8;
   localparam int BASE = 32;
   localparam int PTR  = 4;
   localparam logic [31:0] MASK = 32'h80FF_007F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [4:0]  lk_index = '0;
   logic        lk_hit, lk_legacy, lk_parity_err;
   logic [6:0]  lk_addr;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_word = '0;
   logic        busy, asg_req, rsp_valid;
   logic [6:0]  asg_addr;
   logic        asg_ack = 1'b0, asg_none = 1'b0;
   logic [15:0] rsp_len;

   always #10 clk = ~clk;

   dev_addr_table #(.DEPTH(N), .ADDR_W(8), .TBL_BASE(BASE), .PTR_OFS(PTR)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_index(lk_index),
      .lk_hit(lk_hit), .lk_legacy(lk_legacy), .lk_addr(lk_addr),
      .lk_parity_err(lk_parity_err), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .busy(busy), .asg_req(asg_req), .asg_addr(asg_addr), .asg_ack(asg_ack),
      .asg_none(asg_none), .rsp_valid(rsp_valid), .rsp_len(rsp_len)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   // behavioural reference state
   logic [31:0] m_tab [N];
   int m_st = 0;        // 0 idle, 1 walking, 2 responding
   int m_idx = 0;
   int m_left = 0;
   bit seen_rsp = 0;
   int last_len = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic int ones8(input logic [7:0] v);
      int c = 0;
      for (int b = 0; b < 8; b++) if (v[b]) c++;
      return c;
   endfunction

   function automatic logic [31:0] mk_dyn(input logic [6:0] a);
      logic [7:0] f;
      f = {1'b0, a};
      if (ones8(f) % 2 == 0) f[7] = 1'b1;
      return {8'h00, f, 16'h0000};
   endfunction

   function automatic int tbl_idx(input logic [7:0] a);
      if (a >= BASE && a < BASE + 4 * N && a[1:0] == 2'b00) return (a - BASE) / 4;
      return -1;
   endfunction

   task automatic compare_all();
      logic [31:0] e;
      logic [31:0] exp_rd;
      string lt;
      bit h, lg, er;
      logic [6:0] la;
      int ti;
      // register read
      ti = tbl_idx(reg_addr);
      if (reg_addr == PTR) exp_rd = {16'(N), 8'h00, 8'(BASE)};
      else if (ti >= 0) exp_rd = m_tab[ti];
      else exp_rd = '0;
      chk((reg_addr == PTR) ? "R1 pointer" : "R2 rdata", reg_rdata, exp_rd);
      // lookup
      e = (lk_index < N) ? m_tab[lk_index] : 32'h0;
      h = (e != 0);
      lg = h && e[31];
      er = h && !e[31] && (ones8(e[23:16]) % 2 == 0);
      la = (!h || er) ? 7'd0 : (e[31] ? e[6:0] : e[22:16]);
      lt = !h ? "R5" : (er ? "R4" : "R3");
      chk({lt, " lk_hit"}, {31'b0, lk_hit}, {31'b0, h});
      chk({lt, " lk_legacy"}, {31'b0, lk_legacy}, {31'b0, lg});
      chk({lt, " lk_parity_err"}, {31'b0, lk_parity_err}, {31'b0, er});
      chk({lt, " lk_addr"}, {25'b0, lk_addr}, {25'b0, la});
      // sequencer
      chk("R11 busy", {31'b0, busy}, {31'b0, m_st != 0});
      chk("R7 asg_req", {31'b0, asg_req}, {31'b0, (m_st == 1 && m_left != 0)});
      chk("R7 asg_addr", {25'b0, asg_addr},
          (m_st == 1 && m_left != 0) ? {25'b0, m_tab[m_idx][22:16]} : 32'h0);
      chk("R11 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_st == 2});
      chk("R8 rsp_len", {16'b0, rsp_len}, (m_st == 2) ? 32'(m_left) : 32'h0);
      if (rsp_valid) begin
         seen_rsp = 1;
         last_len = int'(rsp_len);
      end
   endtask

   task automatic model_edge();
      int ti, st, cnt, room;
      ti = tbl_idx(reg_addr);
      if (m_st == 0 && reg_wr && ti >= 0) m_tab[ti] = reg_wdata & MASK;
      case (m_st)
         0: if (cmd_valid && cmd_word[2:0] == 3'd3) begin
               st = int'(cmd_word[20:16]);
               cnt = int'(cmd_word[25:21]);
               room = (st < N) ? N - st : 0;
               m_left = (cnt < room) ? cnt : room;
               m_idx = st;
               m_st = 1;
            end
         1: begin
               if (m_left == 0) m_st = 2;
               else if (asg_ack) begin
                  m_idx++;
                  m_left--;
                  if (m_left == 0) m_st = 2;
               end else if (asg_none) m_st = 2;
            end
         default: m_st = 0;
      endcase
   endtask

   // one clock: inputs already set after a falling edge
   task automatic cycle();
      #2;
      compare_all();
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = d;
      cycle();
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
      reg_addr = 8'(a);
      #2;
      chk(tag, reg_rdata, exp);
      cycle();
   endtask

   function automatic logic [31:0] mk_cmd(input int typ, input int st, input int cnt);
      return {6'b0, 5'(cnt), 5'(st), 13'b0, 3'(typ)};
   endfunction

   // issue a command, acknowledge nack offers, then report no more devices
   task automatic run(input logic [31:0] w, input int nack);
      int n = 0;
      seen_rsp = 0;
      cmd_valid = 1'b1; cmd_word = w;
      cycle();
      cmd_valid = 1'b0;
      for (int k = 0; k < 60 && m_st != 0; k++) begin
         if (m_st == 1 && m_left != 0) begin
            if (n < nack) begin asg_ack = 1'b1; n++; end
            else asg_none = 1'b1;
         end
         cycle();
         asg_ack = 1'b0; asg_none = 1'b0;
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         report();
      end
   end

   initial begin
      for (int i = 0; i < N; i++) m_tab[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      rd_chk("R2 reset entry0", BASE, 32'h0);
      chk("R11 reset busy", {31'b0, busy}, 32'h0);
      rd_chk("R1 pointer", PTR, {16'(N), 8'h00, 8'(BASE)});
      wr(PTR, 32'hFFFF_FFFF);
      rd_chk("R1 pointer after write", PTR, {16'(N), 8'h00, 8'(BASE)});
      // legacy entry with junk bits
      wr(BASE + 4, 32'hFF00_FFD0);
      rd_chk("R2 masked entry1", BASE + 4, 32'h8000_0050);
      lk_index = 5'd1; #2;
      chk("R3 legacy addr", {25'b0, lk_addr}, 32'h50);
      cycle();
      // correct and wrong parity dynamic entries
      wr(BASE + 8, 32'h0089_0000);
      lk_index = 5'd2; #2;
      chk("R3 dyn addr", {25'b0, lk_addr}, 32'h09);
      cycle();
      wr(BASE + 12, 32'h0009_0000);
      lk_index = 5'd3; #2;
      chk("R4 parity err", {31'b0, lk_parity_err}, 32'h1);
      cycle();
      wr(BASE + 8, 32'h0);
      lk_index = 5'd2; #2;
      chk("R5 freed entry", {31'b0, lk_hit}, 32'h0);
      cycle();
      lk_index = 5'd20; cycle();
      rd_chk("R2 unmapped", BASE + 4 * N, 32'h0);
      rd_chk("R2 unaligned", BASE + 5, 32'h0);
      // fill table with dynamic addresses
      for (int i = 0; i < N; i++) wr(BASE + 4 * i, mk_dyn(7'(8'h10 + i)));
      lk_index = 5'd4; cycle();
      // wrong command type
      run(mk_cmd(1, 0, 3), 3);
      chk("R6 bad type not busy", {31'b0, busy}, 32'h0);
      chk("R6 no response", {31'b0, seen_rsp}, 32'h0);
      // count used up
      run(mk_cmd(3, 2, 3), 5);
      chk("R9 full run rsp seen", {31'b0, seen_rsp}, 32'h1);
      chk("R9 full run leftover", 32'(last_len), 32'h0);
      // no more devices after one
      run(mk_cmd(3, 1, 4), 1);
      chk("R8 early stop leftover", 32'(last_len), 32'h3);
      // clipped count
      run(mk_cmd(3, 6, 5), 9);
      chk("R9 clipped leftover", 32'(last_len), 32'h0);
      run(mk_cmd(3, 6, 5), 0);
      chk("R8 clipped no device", 32'(last_len), 32'h2);
      // zero effective counts
      run(mk_cmd(3, 3, 0), 0);
      chk("R9 zero count rsp", {31'b0, seen_rsp}, 32'h1);
      run(mk_cmd(3, 12, 4), 0);
      chk("R9 start beyond depth rsp", {31'b0, seen_rsp}, 32'h1);
      // write during a run is ignored
      cmd_valid = 1'b1; cmd_word = mk_cmd(3, 0, 2);
      cycle();
      cmd_valid = 1'b0;
      wr(BASE + 20, 32'h8000_0011);
      asg_ack = 1'b1; cycle(); cycle(); asg_ack = 1'b0;
      cycle();
      rd_chk("R10 entry5 unchanged", BASE + 20, mk_dyn(7'h15));
      lk_index = 5'd5; #2;
      chk("R10 lookup unchanged", {25'b0, lk_addr}, 32'h15);
      cycle();
      repeat (3) cycle();
      done = 1;
      report();
   end

endmodule